// File: doc/BRIEF.md
# Multi-source output value resolver

This block settles the final value of one output signal when several independent sources want to drive it. Each of the `NUM_SRC` sources offers a `DATA_W`-bit candidate and a flag saying whether that candidate is binding in the current cycle. When at least one source holds its flag, the output takes the candidate of the binding source with the lowest index. When no source is binding, the output falls back either to all zeros or to bits of an internal linear feedback shift register, chosen at elaboration by `RAND_FILL`.

An optional checker, enabled by `CHECK_EN`, raises a disagreement flag in the same cycle that any two binding candidates differ. This lets a system built from many independently derived constraints catch contradictions while it runs. The value path and the disagreement flag are purely combinational. The only state is the shift register, which moves one step on every clock edge outside reset.

Top module: `vres_resolver`

## Requirements
- R1: While `rst_n` is low, the shift register holds the seed. The seed is the low `LFSR_W` bits of the repeated byte pattern A5 (hex), which is 8'hA5 at the default width. With no binding source and `RAND_FILL=1`, `val_o` then shows the low `DATA_W` bits of the seed (4'h5 at the defaults).
- R2: With `RAND_FILL=0` and every bit of `src_pend_i` clear, `val_o` is zero.
- R3: With `RAND_FILL=1` and every bit of `src_pend_i` clear, `val_o` equals the low `DATA_W` bits of the shift register. At the default width of 8, the register shifts toward the MSB on each rising clock edge with `rst_n` high, and takes as its new bit 0 the XOR of its bits 7, 5, 4 and 3. The register never holds zero.
- R4: When any bit of `src_pend_i` is set, `val_o` equals the candidate of the lowest set index i. Candidate i occupies bits `[i*DATA_W +: DATA_W]` of `src_val_i`.
- R5: `val_o` and `err_o` follow changes on `src_val_i` and `src_pend_i` within the same cycle, with no clock edge in between.
- R6: `err_o` is 0 whenever fewer than two bits of `src_pend_i` are set.
- R7: With `CHECK_EN=1`, `err_o` is 1 exactly when some binding candidate differs from the selected one.
- R8: Candidates whose flag is clear have no effect on `val_o` or `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the shift register and the assertions |
| rst_n | input | 1 | Active-low synchronous reset, loads the seed |
| src_val_i | input | NUM_SRC*DATA_W | Packed candidate values, source i at bits [i*DATA_W +: DATA_W] |
| src_pend_i | input | NUM_SRC | Per-source binding flags |
| val_o | output | DATA_W | Resolved value |
| err_o | output | 1 | Binding candidates disagree |

## Verification
The selected value, the zero fill and the disagreement flag have no register in their path. They are therefore checked one time step after the inputs change, inside the same low clock phase, and one check applies a second stimulus within that phase to confirm that no edge is needed. The random fill depends on how many rising edges have passed since reset, so the bench steps its own model of the shift register on each rising edge and compares it at the following falling edge. The sweep visits every pattern of binding flags, each combined with many candidate sets. Some of those sets make all candidates equal and others make them differ.

// File: rtl/vres_pkg.sv
`timescale 1ns/1ps
package vres_pkg;

   // Maximal-length feedback masks for the supported register widths
   function automatic logic [31:0] lfsr_taps(input int unsigned width);
      case (width)
         8:       return 32'h0000_00B8;
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic bit lfsr_width_ok(input int unsigned width);
      return lfsr_taps(width) != 32'h0;
   endfunction

   // Seed: repeated A5 byte, cut to the register width
   function automatic logic [31:0] lfsr_seed(input int unsigned width);
      logic [31:0] pat;
      pat = 32'hA5A5_A5A5;
      return pat >> (32 - width);
   endfunction

endpackage

// File: rtl/vres_lowest_pick.sv
`timescale 1ns/1ps
module vres_lowest_pick #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned DATA_W  = 4
) (
   input  logic [NUM_SRC*DATA_W-1:0] vals_i,
   input  logic [NUM_SRC-1:0]        pend_i,
   output logic [NUM_SRC-1:0]        sel_oh_o,
   output logic [DATA_W-1:0]         sel_val_o,
   output logic                      any_o
);
   localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

   logic [NUM_SRC-1:0] oh;
   logic [DATA_W-1:0]  masked [NUM_SRC];

   // isolate lowest set flag
   assign oh = pend_i & ~(pend_i - ONE);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_mask
         assign masked[gi] = vals_i[gi*DATA_W +: DATA_W] & {DATA_W{oh[gi]}};
      end
   endgenerate

   always_comb begin
      sel_val_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         sel_val_o = sel_val_o | masked[i];
      end
   end

   assign sel_oh_o = oh;
   assign any_o    = |pend_i;

endmodule

// File: rtl/vres_disagree.sv
`timescale 1ns/1ps
module vres_disagree #(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned DATA_W   = 4,
   parameter bit          CHECK_EN = 1'b1
) (
   input  logic [NUM_SRC*DATA_W-1:0] vals_i,
   input  logic [NUM_SRC-1:0]        pend_i,
   input  logic [DATA_W-1:0]         ref_i,
   output logic                      err_o
);
   generate
      if (CHECK_EN) begin : g_check
         logic [NUM_SRC-1:0] diff;
         genvar gi;
         for (gi = 0; gi < NUM_SRC; gi++) begin : g_cmp
            assign diff[gi] = pend_i[gi] &&
                              (vals_i[gi*DATA_W +: DATA_W] != ref_i);
         end
         assign err_o = |diff;
      end else begin : g_off
         logic unused;
         assign unused = ^{vals_i, pend_i, ref_i};
         assign err_o  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/vres_lfsr.sv
`timescale 1ns/1ps
module vres_lfsr #(
   parameter int unsigned LFSR_W = 8,
   parameter int unsigned OUT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] bits_o
);
   localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(vres_pkg::lfsr_taps(LFSR_W));
   localparam logic [LFSR_W-1:0] SEED = LFSR_W'(vres_pkg::lfsr_seed(LFSR_W));

   logic [LFSR_W-1:0] state_q;
   logic              fb;

   assign fb = ^(state_q & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= {state_q[LFSR_W-2:0], fb};
   end

   assign bits_o = state_q[OUT_W-1:0];

   // R3: register is never stuck at zero and keeps moving
   assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != '0);
   assert_lfsr_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> state_q != $past(state_q));

endmodule

// File: rtl/vres_resolver.sv
`timescale 1ns/1ps
module vres_resolver #(
   parameter int unsigned NUM_SRC   = 4,
   parameter int unsigned DATA_W    = 4,
   parameter bit          RAND_FILL = 1'b0,
   parameter bit          CHECK_EN  = 1'b1,
   parameter int unsigned LFSR_W    = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC*DATA_W-1:0] src_val_i,
   input  logic [NUM_SRC-1:0]        src_pend_i,
   output logic [DATA_W-1:0]         val_o,
   output logic                      err_o
);
   localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

   initial begin
      assert (NUM_SRC >= 1) else $error("NUM_SRC must be at least 1");
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (vres_pkg::lfsr_width_ok(LFSR_W)) else $error("unsupported LFSR_W");
      assert (LFSR_W >= DATA_W) else $error("LFSR_W must cover DATA_W");
   end

   logic [NUM_SRC-1:0] sel_oh;
   logic [DATA_W-1:0]  sel_val;
   logic               any_pend;
   logic [DATA_W-1:0]  fill;

   vres_lowest_pick #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_pick (
      .vals_i   (src_val_i),
      .pend_i   (src_pend_i),
      .sel_oh_o (sel_oh),
      .sel_val_o(sel_val),
      .any_o    (any_pend)
   );

   vres_disagree #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .CHECK_EN(CHECK_EN)) u_cmp (
      .vals_i(src_val_i),
      .pend_i(src_pend_i),
      .ref_i (sel_val),
      .err_o (err_o)
   );

   generate
      if (RAND_FILL) begin : g_rand
         vres_lfsr #(.LFSR_W(LFSR_W), .OUT_W(DATA_W)) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .bits_o(fill)
         );
      end else begin : g_zero
         assign fill = '0;
         // R2: nothing binding gives zero
         assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (src_pend_i == '0) |-> (val_o == '0));
      end
   endgenerate

   assign val_o = any_pend ? sel_val : fill;

   // R4: picker selects exactly one binding source, the lowest one
   assert_pick_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_oh) && ((sel_oh & ~src_pend_i) == '0)
      && (((sel_oh - ONE) & src_pend_i) == '0)
      && ((src_pend_i != '0) == (sel_oh != '0)));
   assert_src0_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      src_pend_i[0] |-> (val_o == src_val_i[DATA_W-1:0]));
   // R6: a lone binding source cannot disagree
   assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(src_pend_i) <= 1) |-> !err_o);
   // R7: disagreement needs two binding sources
   assert_err_needs_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($countones(src_pend_i) >= 2));

endmodule

// File: tb/vres_resolver_tb.sv
`timescale 1ns/1ps
module vres_resolver_tb;
   localparam int N = 4;
   localparam int W = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst_n;
   logic [N*W-1:0] vals;
   logic [N-1:0]   pend;
   logic [W-1:0]   val_z, val_r;
   logic           err_z, err_r;
   int             n_chk = 0;
   int             n_err = 0;
   logic [7:0]     mdl;

   vres_resolver #(.NUM_SRC(N), .DATA_W(W), .RAND_FILL(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_val_i(vals), .src_pend_i(pend),
      .val_o(val_z), .err_o(err_z));

   vres_resolver #(.NUM_SRC(N), .DATA_W(W), .RAND_FILL(1'b1)) u_dut_rnd (
      .clk(clk), .rst_n(rst_n), .src_val_i(vals), .src_pend_i(pend),
      .val_o(val_r), .err_o(err_r));

   // reference shift register per R1/R3
   always @(posedge clk) begin
      if (!rst_n) mdl <= 8'hA5;
      else        mdl <= {mdl[6:0], mdl[7] ^ mdl[5] ^ mdl[4] ^ mdl[3]};
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_val(input logic [N-1:0] p,
                                            input logic [N*W-1:0] v,
                                            input logic [W-1:0] fillv);
      logic [W-1:0] r;
      r = fillv;
      for (int i = N - 1; i >= 0; i--) if (p[i]) r = v[i*W +: W];
      return r;
   endfunction

   function automatic logic exp_err(input logic [N-1:0] p, input logic [N*W-1:0] v);
      logic [W-1:0] s;
      logic         e;
      s = exp_val(p, v, '0);
      e = 1'b0;
      for (int i = 0; i < N; i++) if (p[i] && v[i*W +: W] != s) e = 1'b1;
      return e;
   endfunction

   task automatic apply(input logic [N-1:0] p, input logic [N*W-1:0] v, input string tag);
      pend = p;
      vals = v;
      #1;
      check({tag, " zero-fill val"}, 32'(val_z), 32'(exp_val(p, v, '0)));
      check({tag, " rand-fill val"}, 32'(val_r), 32'(exp_val(p, v, mdl[W-1:0])));
      check({tag, " err"}, 32'(err_z), 32'(exp_err(p, v)));
      check({tag, " err rnd"}, 32'(err_r), 32'(exp_err(p, v)));
   endtask

   initial begin
      #800000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      pend  = '0;
      vals  = 16'h9C3E;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: seed visible during reset, zero-fill unit gives zero
      check("R1 seed", 32'(val_r), 32'h5);
      check("R1 zero unit", 32'(val_z), 32'h0);
      check("R1 err", 32'(err_r), 32'h0);
      rst_n = 1'b1;

      // R3: free-running random fill against the model
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         apply('0, 16'(c * 16'h3F1D), "R2_R3");
      end

      // R4/R6/R7/R8: every flag pattern with many candidate sets
      for (int p = 0; p < 16; p++) begin
         for (int k = 0; k < 24; k++) begin
            logic [N*W-1:0] v;
            string          tag;
            v = 16'((p * 16'h2B1D + k * 16'h9E37) ^ (k << 3));
            if (k % 3 == 0) v = {N{4'(k)}};
            if (p == 0) tag = "R2_R3";
            else if ($countones(4'(p)) == 1) tag = "R4_R6";
            else tag = "R4_R7_R8";
            @(negedge clk);
            apply(4'(p), v, tag);
         end
      end

      // R5: two stimuli within one low phase, no edge between them
      @(negedge clk);
      apply(4'b1010, 16'h7A3C, "R5 first");
      apply(4'b0100, 16'h7A3C, "R5 second");

      // R8: change only non-binding candidates, result stays put
      @(negedge clk);
      apply(4'b0010, 16'h0060, "R8 base");
      check("R8 base val", 32'(val_z), 32'h6);
      apply(4'b0010, 16'hF06F, "R8 moved");
      check("R8 held val", 32'(val_z), 32'h6);
      check("R8 held err", 32'(err_z), 32'h0);

      // R7: two binding candidates equal, then differing
      @(negedge clk);
      apply(4'b1001, 16'h3003, "R7 equal");
      check("R7 equal err", 32'(err_z), 32'h0);
      apply(4'b1001, 16'h3004, "R7 differ");
      check("R7 differ err", 32'(err_z), 32'h1);
      check("R4 lowest", 32'(val_z), 32'h4);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule